// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between a processor core and its two external interrupt pins. Both pins arrive asynchronous to the core clock and pass through synchronizers first. The maskable request is a level. It is honoured only while the core's interrupt-enable flag is set, and only if it has been seen steadily active for a lead time before the core signals the end of an instruction. When honoured, the block runs two interrupt-acknowledge bus cycles with the bus locked, and takes the 8-bit vector from the data bus during the second one.

The non-maskable request works as an edge detector. After synchronization, a rising edge counts only if a low run of a minimum length comes before it and a high run of a minimum length follows it. A counted edge is latched and reported at the next instruction boundary with the fixed vector 2. It runs no bus cycles and does not look at the enable flag.

The core sees a single pending request, made of a flag, a source bit and a vector. The request stays asserted until the core strobes that it has taken it.

Top module: `irq_front_end`

## Requirements
- R1: Out of reset, irq_pending, inta_active and lock_out are all low.
- R2: While ie_flag is low at an instruction boundary, a maskable request starts no acknowledge cycle and produces no pending request.
- R3: A maskable request is accepted at a boundary only if intr_in has been high for at least SYNC_STAGES+INTR_LEAD clock edges before the edge that samples insn_boundary (4 with default parameters).
- R4: An accepted maskable request runs exactly two acknowledge cycles, each ending on an edge with bus_ready high. inta_second is 0 in the first and 1 in the second. irq_vector is taken from bus_data at the end of the second, and irq_from_nmi is then 0.
- R5: lock_out is high on every cycle in which inta_active is high, including wait states, and is low once the request is pending.
- R6: If intr_in drops while the block waits for bus_free before the first acknowledge cycle, the request is dropped, with no acknowledge cycle and no pending request.
- R7: A non-maskable request is reported with irq_from_nmi=1 and irq_vector=2, runs no acknowledge cycle, and does not depend on ie_flag.
- R8: A non-maskable edge is accepted only when nmi_in was low for at least NMI_MIN_LOW cycles and then stays high for at least NMI_MIN_HIGH cycles (4 and 4 by default). A shorter low or high run is ignored.
- R9: When both requests are ready at the same boundary, the non-maskable one is reported first. The maskable one is served at a later boundary.
- R10: While an accepted non-maskable request has not been taken, further non-maskable edges are discarded.
- R11: irq_pending, irq_from_nmi and irq_vector stay unchanged until irq_taken is high on a clock edge. irq_pending is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_in | input | 1 | Maskable request, active-high level, asynchronous |
| nmi_in | input | 1 | Non-maskable request, asynchronous |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| insn_boundary | input | 1 | Strobe: current instruction ends this cycle |
| bus_free | input | 1 | Bus may start an acknowledge cycle |
| bus_ready | input | 1 | Ends the current acknowledge cycle |
| bus_data | input | VEC_W | Data bus, vector sampled in the second acknowledge |
| irq_taken | input | 1 | Core has accepted the pending request |
| inta_active | output | 1 | An acknowledge bus cycle is in progress |
| inta_second | output | 1 | 0 = first, 1 = second acknowledge cycle |
| lock_out | output | 1 | Bus lock across the acknowledge pair |
| irq_pending | output | 1 | A request is waiting for the core |
| irq_from_nmi | output | 1 | Pending request came from the non-maskable input |
| irq_vector | output | VEC_W | Vector of the pending request |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a lead of two, and minimum NMI runs of four. With these values every interesting width sits within a sweep of at most six cycles. The bench sweeps the INTR lead time from 0 to 6 cycles, with zero to two acknowledge wait states, so both sides of the acceptance threshold are covered. It also sweeps every NMI low and high run from 1 to 6 cycles, with the enable flag alternating. Directed sequences cover masking, cancellation while waiting for the bus, priority, and the discarding of a second NMI edge.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_ACK1,
    ST_ACK2,
    ST_PEND
  } fe_state_t;

  localparam int NMI_VECTOR_VALUE = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/intr_level_qual.sv
module intr_level_qual #(
  parameter int LEAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_s,
  output logic level_ok
);
  localparam int CW = $clog2(LEAD + 1);

  logic [CW-1:0] run_q;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == CW'(LEAD)) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (!level_s) run_q <= '0;
    else               run_q <= bump(run_q);
  end

  assign level_ok = level_s && (run_q == CW'(LEAD));
endmodule

// File: rtl/nmi_edge_qual.sv
module nmi_edge_qual #(
  parameter int MIN_LOW  = 4,
  parameter int MIN_HIGH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic edge_ok
);
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam int HW = $clog2(MIN_HIGH + 1);

  logic [LW-1:0] low_q;
  logic [HW-1:0] high_q;

  function automatic logic [LW-1:0] bump_low(input logic [LW-1:0] v);
    return (v == LW'(MIN_LOW)) ? v : v + 1'b1;
  endfunction

  function automatic logic [HW-1:0] bump_high(input logic [HW-1:0] v);
    return (v == HW'(MIN_HIGH)) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (!pin_s) begin
      high_q <= '0;
      low_q  <= (high_q != '0) ? LW'(1) : bump_low(low_q);
    end else begin
      high_q <= bump_high(high_q);
    end
  end

  // low_q keeps the length of the preceding low run during a high run
  assign edge_ok = pin_s && (high_q == HW'(MIN_HIGH - 1)) && (low_q == LW'(MIN_LOW));
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
  import irq_fe_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int INTR_LEAD    = 2,
  parameter int NMI_MIN_LOW  = 4,
  parameter int NMI_MIN_HIGH = 4,
  parameter int VEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intr_in,
  input  logic             nmi_in,
  input  logic             ie_flag,
  input  logic             insn_boundary,
  input  logic             bus_free,
  input  logic             bus_ready,
  input  logic [VEC_W-1:0] bus_data,
  input  logic             irq_taken,
  output logic             inta_active,
  output logic             inta_second,
  output logic             lock_out,
  output logic             irq_pending,
  output logic             irq_from_nmi,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int NPINS = 2;
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NMI_VECTOR_VALUE);

  logic [NPINS-1:0] raw_pins;
  logic [NPINS-1:0] sync_pins;
  logic intr_s, nmi_s;
  logic intr_ok, nmi_fire;
  logic nmi_held_q;
  logic start_nmi, start_intr, cancel_arm, nmi_clear;
  logic in_idle, in_arm, in_ack;
  fe_state_t state_q, state_d;
  logic [VEC_W-1:0] vec_q;
  logic from_nmi_q, lock_q;

  assign raw_pins = {nmi_in, intr_in};

  for (genvar p = 0; p < NPINS; p++) begin : g_sync
    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_pins[p]),
      .q    (sync_pins[p])
    );
  end

  assign intr_s = sync_pins[0];
  assign nmi_s  = sync_pins[1];

  intr_level_qual #(.LEAD(INTR_LEAD)) u_intr_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_s (intr_s),
    .level_ok(intr_ok)
  );

  nmi_edge_qual #(.MIN_LOW(NMI_MIN_LOW), .MIN_HIGH(NMI_MIN_HIGH)) u_nmi_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_s  (nmi_s),
    .edge_ok(nmi_fire)
  );

  assign in_idle    = (state_q == ST_IDLE);
  assign in_arm     = (state_q == ST_ARM);
  assign in_ack     = (state_q == ST_ACK1) || (state_q == ST_ACK2);
  assign start_nmi  = in_idle && insn_boundary && nmi_held_q;
  assign start_intr = in_idle && insn_boundary && !nmi_held_q && ie_flag && intr_ok;
  assign cancel_arm = in_arm && !intr_s;
  assign nmi_clear  = (state_q == ST_PEND) && from_nmi_q && irq_taken;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_nmi)       state_d = ST_PEND;
        else if (start_intr) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (cancel_arm)    state_d = ST_IDLE;
        else if (bus_free) state_d = ST_ACK1;
      end
      ST_ACK1: if (bus_ready) state_d = ST_ACK2;
      ST_ACK2: if (bus_ready) state_d = ST_PEND;
      ST_PEND: if (irq_taken) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vec_q      <= '0;
      from_nmi_q <= 1'b0;
      lock_q     <= 1'b0;
      nmi_held_q <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= (state_d == ST_ACK1) || (state_d == ST_ACK2);
      if (start_nmi) begin
        vec_q      <= NMI_VEC;
        from_nmi_q <= 1'b1;
      end else if ((state_q == ST_ACK2) && bus_ready) begin
        vec_q      <= bus_data;
        from_nmi_q <= 1'b0;
      end
      if (nmi_clear)                   nmi_held_q <= 1'b0;
      else if (nmi_fire && !nmi_held_q) nmi_held_q <= 1'b1;
    end
  end

  assign inta_active  = in_ack;
  assign inta_second  = (state_q == ST_ACK2);
  assign lock_out     = lock_q;
  assign irq_pending  = (state_q == ST_PEND);
  assign irq_from_nmi = from_nmi_q;
  assign irq_vector   = vec_q;
endmodule

// File: rtl/irq_front_end_chk.sv
module irq_front_end_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ie_flag,
  input logic             insn_boundary,
  input logic             bus_ready,
  input logic             irq_taken,
  input logic             inta_active,
  input logic             inta_second,
  input logic             lock_out,
  input logic             irq_pending,
  input logic             irq_from_nmi,
  input logic [VEC_W-1:0] irq_vector,
  input logic             in_idle,
  input logic             in_arm,
  input logic             nmi_held_q,
  input logic             nmi_clear
);
  a_r5_lock_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    inta_active |-> lock_out);

  a_r5_unlock_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !lock_out);

  a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && insn_boundary && !ie_flag) |=> !in_arm);

  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_active && !inta_second && bus_ready) |=> (inta_active && inta_second));

  a_r7_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && irq_from_nmi) |-> (irq_vector == VEC_W'(2)));

  a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && insn_boundary && nmi_held_q) |=> (irq_pending && irq_from_nmi));

  a_r10_nmi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_held_q && !nmi_clear) |=> nmi_held_q);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_taken) |=>
      (irq_pending && $stable(irq_vector) && $stable(irq_from_nmi)));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inta_active, irq_pending, in_arm}));
endmodule

bind irq_front_end irq_front_end_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ie_flag      (ie_flag),
  .insn_boundary(insn_boundary),
  .bus_ready    (bus_ready),
  .irq_taken    (irq_taken),
  .inta_active  (inta_active),
  .inta_second  (inta_second),
  .lock_out     (lock_out),
  .irq_pending  (irq_pending),
  .irq_from_nmi (irq_from_nmi),
  .irq_vector   (irq_vector),
  .in_idle      (in_idle),
  .in_arm       (in_arm),
  .nmi_held_q   (nmi_held_q),
  .nmi_clear    (nmi_clear)
);

// File: tb/sim_irq_front_end.sv
module sim_irq_front_end;
  localparam int SYNC = 2;
  localparam int LEAD = 2;
  localparam int NLOW = 4;
  localparam int NHIGH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intr_in = 1'b0, nmi_in = 1'b0, ie_flag = 1'b1, insn_boundary = 1'b0;
  logic bus_free = 1'b1, bus_ready = 1'b0, irq_taken = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic inta_active, inta_second, lock_out, irq_pending, irq_from_nmi;
  logic [7:0] irq_vector;

  int checks = 0;
  int fails = 0;
  int ack_count = 0;
  int ack_wait = 0;
  int wait_cnt = 0;
  int lock_bad = 0;
  logic [7:0] resp_vec = 8'h00;
  logic ack_flag [0:3];
  bit finished = 0;

  always #5 clk = ~clk;

  irq_front_end u0 (
    .clk(clk), .rst_n(rst_n), .intr_in(intr_in), .nmi_in(nmi_in),
    .ie_flag(ie_flag), .insn_boundary(insn_boundary), .bus_free(bus_free),
    .bus_ready(bus_ready), .bus_data(bus_data), .irq_taken(irq_taken),
    .inta_active(inta_active), .inta_second(inta_second), .lock_out(lock_out),
    .irq_pending(irq_pending), .irq_from_nmi(irq_from_nmi), .irq_vector(irq_vector)
  );

  // bus responder: ends each acknowledge cycle after ack_wait wait states
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      wait_cnt = 0;
    end else if (inta_active) begin
      if (!lock_out) lock_bad++;
      if (wait_cnt >= ack_wait) begin
        bus_ready = 1'b1;
        bus_data = inta_second ? resp_vec : 8'hEE;
        if (ack_count < 4) ack_flag[ack_count] = inta_second;
        ack_count++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    insn_boundary = 1'b1;
    step(1);
    insn_boundary = 1'b0;
  endtask

  task automatic take(input string tag);
    irq_taken = 1'b1;
    step(1);
    irq_taken = 1'b0;
    check(irq_pending == 1'b0, tag, irq_pending, 0);
  endtask

  task automatic nmi_pulse(input int lo, input int hi);
    nmi_in = 1'b0; step(lo);
    nmi_in = 1'b1; step(hi);
    nmi_in = 1'b0; step(8);
  endtask

  function automatic bit intr_accepts(input int k);
    return k >= SYNC + LEAD;
  endfunction

  function automatic bit nmi_accepts(input int lo, input int hi);
    return (lo >= NLOW) && (hi >= NHIGH);
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check(irq_pending == 1'b0, "R1 pending", irq_pending, 0);
    check(inta_active == 1'b0, "R1 inta", inta_active, 0);
    check(lock_out == 1'b0, "R1 lock", lock_out, 0);
    rst_n = 1'b1;
    step(8);

    // R3 lead sweep with R4/R5 acknowledge checks, varying wait states
    for (int k = 0; k <= 6; k++) begin
      bit exp;
      exp = intr_accepts(k);
      ack_count = 0; lock_bad = 0; ack_wait = k % 3;
      resp_vec = 8'h40 + 8'(k);
      intr_in = 1'b0; step(8);
      intr_in = 1'b1; step(k);
      strobe();
      step(25);
      check(ack_count == (exp ? 2 : 0), "R3 ack count", ack_count, exp ? 2 : 0);
      check(irq_pending == exp, "R3 pending", irq_pending, exp);
      if (exp) begin
        check(ack_flag[0] == 1'b0, "R4 first flag", ack_flag[0], 0);
        check(ack_flag[1] == 1'b1, "R4 second flag", ack_flag[1], 1);
        check(irq_vector == resp_vec, "R4 vector", irq_vector, resp_vec);
        check(irq_from_nmi == 1'b0, "R4 source", irq_from_nmi, 0);
        check(lock_bad == 0, "R5 lock in ack", lock_bad, 0);
        check(lock_out == 1'b0, "R5 lock after", lock_out, 0);
        intr_in = 1'b0;
        take("R11 cleared");
      end
      intr_in = 1'b0;
    end

    // R2 masked
    ack_count = 0;
    ie_flag = 1'b0; intr_in = 1'b1; step(8);
    strobe(); step(20);
    check(ack_count == 0, "R2 no ack", ack_count, 0);
    check(irq_pending == 1'b0, "R2 no pending", irq_pending, 0);
    ie_flag = 1'b1; intr_in = 1'b0; step(8);

    // R6 cancel while waiting for the bus
    ack_count = 0; bus_free = 1'b0;
    intr_in = 1'b1; step(8);
    strobe(); intr_in = 1'b0; step(6);
    bus_free = 1'b1; step(15);
    check(ack_count == 0, "R6 no ack", ack_count, 0);
    check(irq_pending == 1'b0, "R6 no pending", irq_pending, 0);
    // R5/R6 held request proceeds once the bus frees
    ack_count = 0; lock_bad = 0; bus_free = 1'b0; ack_wait = 1; resp_vec = 8'h9C;
    intr_in = 1'b1; step(8);
    strobe(); step(6);
    check(lock_out == 1'b0, "R5 no lock while waiting", lock_out, 0);
    bus_free = 1'b1; step(20);
    check(ack_count == 2, "R6 late ack", ack_count, 2);
    check(irq_vector == 8'h9C, "R4 late vector", irq_vector, 8'h9C);
    check(lock_bad == 0, "R5 lock waits", lock_bad, 0);
    intr_in = 1'b0;
    take("R11 late");
    step(4);

    // R8 width sweep, R7 vector and enable independence
    for (int lo = 1; lo <= 6; lo++) begin
      for (int hi = 1; hi <= 6; hi++) begin
        bit exp;
        exp = nmi_accepts(lo, hi);
        ack_count = 0;
        ie_flag = lo[0];
        nmi_in = 1'b1; step(2);
        nmi_pulse(lo, hi);
        strobe(); step(3);
        check(irq_pending == exp, "R8 width", irq_pending, exp);
        if (exp) begin
          check(irq_from_nmi == 1'b1, "R7 source", irq_from_nmi, 1);
          check(irq_vector == 8'd2, "R7 vector", irq_vector, 2);
          check(ack_count == 0, "R7 no ack", ack_count, 0);
          take("R11 nmi");
        end
      end
    end
    ie_flag = 1'b1;

    // R9 priority, with R11 hold
    ack_count = 0; ack_wait = 0; resp_vec = 8'h77;
    intr_in = 1'b1;
    nmi_pulse(6, 6);
    strobe(); step(3);
    check(irq_pending && irq_from_nmi, "R9 nmi first", irq_from_nmi, 1);
    step(10);
    check(irq_pending && irq_vector == 8'd2, "R11 held", irq_vector, 2);
    take("R11 after nmi");
    strobe(); step(25);
    check(irq_pending && !irq_from_nmi, "R9 intr later", irq_from_nmi, 0);
    check(irq_vector == 8'h77, "R9 intr vector", irq_vector, 8'h77);
    check(ack_count == 2, "R9 ack count", ack_count, 2);
    intr_in = 1'b0;
    take("R11 after intr");

    // R10 second edge discarded while first not taken
    nmi_pulse(6, 6);
    nmi_pulse(6, 6);
    strobe(); step(3);
    check(irq_pending && irq_from_nmi, "R10 first nmi", irq_pending, 1);
    take("R10 take");
    strobe(); step(5);
    check(irq_pending == 1'b0, "R10 second dropped", irq_pending, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule